// File: doc/BRIEF.md
# Hiccup Overload Supervisor

This block watches a regulator's overload-detect line and decides whether the regulator output may be enabled and whether the overload diagnostic flag is raised. A mode input picks between two protection styles. With the mode input high the supervisor acts as a plain current-clamp monitor: the output stays on and the flag mirrors the overload line. With the mode input low it performs hiccup limiting. A detected overload shuts the output off for an off window of `T_OFF_CYC` clock cycles. The output then comes back for an on window one tenth as long, and the off/on cycle repeats until one complete on window passes without any overload.

A run input puts the whole block in standby. In standby the output is off, the flag is clear and all timers are reset. System software can start a heavily capacitive load in clamp mode and change to hiccup mode once the load has charged. The mode input is only acted on while the supervisor is in its normal state, so a hiccup cycle that has already started always runs to its end. All window lengths are counted in clock cycles, and the on window length is derived from the off window length.

Top module: `ovl_guard`

## Requirements
- R1: While `run_i` is sampled low at a clock edge, `out_en_o` and `ovl_flag_o` are both 0 after that edge. Any hiccup cycle in progress is abandoned, and a later run restarts in the normal state with no remembered overload.
- R2: After reset, `out_en_o` = 0 and `ovl_flag_o` = 0. The first edge with `run_i` high enters the normal state: `out_en_o` = 1 and `ovl_flag_o` = 0 when no overload is present.
- R3: In the normal state with `clamp_mode_i` = 0, an edge that samples `overload_i` = 1 makes `out_en_o` = 0 and `ovl_flag_o` = 1 after that same edge.
- R4: The output stays off for exactly `T_OFF_CYC` cycles, counting the trip cycle. It is then on for `T_OFF_CYC/10` cycles (minimum 1) with the flag still 1. Overload seen while the output is off is ignored.
- R5: Overload sampled at any edge of the on window is remembered. It does not shorten the window. At the window's end it starts a fresh off window, with `out_en_o` = 0 and `ovl_flag_o` = 1.
- R6: If no overload is sampled during a whole on window, then at its end the block returns to normal: `ovl_flag_o` falls to 0 while `out_en_o` stays 1.
- R7: In the normal state with `clamp_mode_i` = 1, `out_en_o` stays 1, and after each edge `ovl_flag_o` equals the `overload_i` value sampled at that edge.
- R8: `clamp_mode_i` is read only in the normal state. Changing it from 1 to 0 there makes the next overload trip a hiccup cycle. Changing it during a hiccup cycle does not alter that cycle's off and on windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Global enable; low forces standby |
| clamp_mode_i | input | 1 | 1 = static clamp monitoring, 0 = hiccup limiting |
| overload_i | input | 1 | Overload detected on the regulator output |
| out_en_o | output | 1 | Regulator output enable (registered) |
| ovl_flag_o | output | 1 | Overload diagnostic flag (registered) |

## Verification
The bench builds the block with `T_OFF_CYC` = 20, so the on window is 2 cycles. Every window boundary then falls within a couple of dozen cycles. This makes it practical to count the off window cycle by cycle and to place a single-cycle overload on each individual edge of the on window: the edge that is ignored during the off-to-on changeover, the first sample and the final sample. The short windows also make room for directed runs that abandon a cycle through the run input and that change the mode in the middle of a cycle.

// File: rtl/ovl_guard_pkg.sv
package ovl_guard_pkg;

  typedef enum logic [1:0] {
    PH_STANDBY  = 2'd0,
    PH_NORMAL   = 2'd1,
    PH_HOLD_OFF = 2'd2,
    PH_PROBE_ON = 2'd3
  } ovl_phase_e;

  // on window is one tenth of the off window, never shorter than one cycle
  function automatic int on_window_len(input int off_len);
    return ((off_len / 10) < 1) ? 1 : (off_len / 10);
  endfunction

  function automatic int count_width(input int max_len);
    return (max_len > 1) ? $clog2(max_len) : 1;
  endfunction

endpackage

// File: rtl/ovl_window_timer.sv
module ovl_window_timer #(
  parameter int CNT_W   = 8,
  parameter int OFF_LEN = 100,
  parameter int ON_LEN  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic load_off_i,
  input  logic load_on_i,
  input  logic tick_i,
  output logic done_o
);

  localparam logic [CNT_W-1:0] OFF_LOAD = CNT_W'(OFF_LEN - 1);
  localparam logic [CNT_W-1:0] ON_LOAD  = CNT_W'(ON_LEN - 1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      remain_q <= '0;
    end else if (load_off_i) begin
      remain_q <= OFF_LOAD;
    end else if (load_on_i) begin
      remain_q <= ON_LOAD;
    end else if (tick_i && (remain_q != '0)) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign done_o = (remain_q == '0);

endmodule

// File: rtl/ovl_hit_latch.sv
module ovl_hit_latch (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic sample_i,
  input  logic det_i,
  output logic seen_o
);

  logic hit_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      hit_q <= 1'b0;
    end else if (sample_i && det_i) begin
      hit_q <= 1'b1;
    end
  end

  // include the current sample so the final edge of a window counts
  assign seen_o = hit_q | (sample_i & det_i);

endmodule

// File: rtl/ovl_seq_fsm.sv
module ovl_seq_fsm
  import ovl_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       clamp_mode_i,
  input  logic       overload_i,
  input  logic       win_done_i,
  input  logic       hit_seen_i,
  output ovl_phase_e phase_o,
  output logic       load_off_o,
  output logic       load_on_o,
  output logic       tick_o,
  output logic       tmr_clear_o,
  output logic       sample_o,
  output logic       hit_clear_o,
  output logic       out_en_o,
  output logic       flag_o
);

  ovl_phase_e phase_q, phase_d;
  logic       out_en_q, flag_q;
  logic       out_en_d, flag_d;
  logic       win_end;

  assign win_end = (phase_q == PH_PROBE_ON) && win_done_i;

  always_comb begin
    phase_d    = phase_q;
    load_off_o = 1'b0;
    load_on_o  = 1'b0;
    if (!run_i) begin
      phase_d = PH_STANDBY;
    end else begin
      unique case (phase_q)
        PH_STANDBY: phase_d = PH_NORMAL;
        PH_NORMAL: begin
          if (!clamp_mode_i && overload_i) begin
            phase_d    = PH_HOLD_OFF;
            load_off_o = 1'b1;
          end
        end
        PH_HOLD_OFF: begin
          if (win_done_i) begin
            phase_d   = PH_PROBE_ON;
            load_on_o = 1'b1;
          end
        end
        PH_PROBE_ON: begin
          if (win_done_i) begin
            if (hit_seen_i) begin
              phase_d    = PH_HOLD_OFF;
              load_off_o = 1'b1;
            end else begin
              phase_d = PH_NORMAL;
            end
          end
        end
        default: phase_d = PH_STANDBY;
      endcase
    end
  end

  assign tick_o      = (phase_q == PH_HOLD_OFF) || (phase_q == PH_PROBE_ON);
  assign tmr_clear_o = !run_i;
  assign sample_o    = run_i && (phase_q == PH_PROBE_ON);
  assign hit_clear_o = !run_i || win_end;

  // outputs follow the phase being entered, so they are registered with it
  always_comb begin
    out_en_d = (phase_d == PH_NORMAL) || (phase_d == PH_PROBE_ON);
    flag_d   = (phase_d == PH_HOLD_OFF) || (phase_d == PH_PROBE_ON) ||
               ((phase_d == PH_NORMAL) && clamp_mode_i && overload_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_STANDBY;
      out_en_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      out_en_q <= out_en_d;
      flag_q   <= flag_d;
    end
  end

  assign phase_o  = phase_q;
  assign out_en_o = out_en_q;
  assign flag_o   = flag_q;

endmodule

// File: rtl/ovl_guard.sv
module ovl_guard
  import ovl_guard_pkg::*;
#(
  parameter int T_OFF_CYC = 900000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic clamp_mode_i,
  input  logic overload_i,
  output logic out_en_o,
  output logic ovl_flag_o
);

  localparam int T_ON_CYC = on_window_len(T_OFF_CYC);
  localparam int CNT_W    = count_width(T_OFF_CYC);

  ovl_phase_e phase_w;
  logic load_off_w, load_on_w, tick_w, tmr_clear_w;
  logic sample_w, hit_clear_w, win_done_w, hit_seen_w;

  ovl_window_timer #(
    .CNT_W  (CNT_W),
    .OFF_LEN(T_OFF_CYC),
    .ON_LEN (T_ON_CYC)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (tmr_clear_w),
    .load_off_i(load_off_w),
    .load_on_i (load_on_w),
    .tick_i    (tick_w),
    .done_o    (win_done_w)
  );

  ovl_hit_latch u_hit (
    .clk     (clk),
    .rst     (rst),
    .clear_i (hit_clear_w),
    .sample_i(sample_w),
    .det_i   (overload_i),
    .seen_o  (hit_seen_w)
  );

  ovl_seq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run_i),
    .clamp_mode_i(clamp_mode_i),
    .overload_i  (overload_i),
    .win_done_i  (win_done_w),
    .hit_seen_i  (hit_seen_w),
    .phase_o     (phase_w),
    .load_off_o  (load_off_w),
    .load_on_o   (load_on_w),
    .tick_o      (tick_w),
    .tmr_clear_o (tmr_clear_w),
    .sample_o    (sample_w),
    .hit_clear_o (hit_clear_w),
    .out_en_o    (out_en_o),
    .flag_o      (ovl_flag_o)
  );

endmodule

// File: rtl/ovl_guard_chk.sv
module ovl_guard_chk
  import ovl_guard_pkg::*;
#(
  parameter int T_OFF_CYC = 900000
) (
  input logic       clk,
  input logic       rst,
  input logic       run_i,
  input logic       clamp_mode_i,
  input logic       overload_i,
  input logic       out_en_o,
  input logic       ovl_flag_o,
  input ovl_phase_e phase_w
);

  localparam int RUN_W = $clog2(T_OFF_CYC + 2) + 1;

  logic [RUN_W-1:0] off_run_q;

  // length of the current stretch with output off and flag raised
  always_ff @(posedge clk) begin
    if (rst) begin
      off_run_q <= '0;
    end else if (run_i && !out_en_o && ovl_flag_o) begin
      off_run_q <= off_run_q + 1'b1;
    end else begin
      off_run_q <= '0;
    end
  end

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (!out_en_o && !ovl_flag_o));

  assert_dynamic_trip_R3: assert property (@(posedge clk) disable iff (rst)
    (run_i && phase_w == PH_NORMAL && !clamp_mode_i && overload_i)
      |=> (!out_en_o && ovl_flag_o));

  assert_off_window_bound_R4: assert property (@(posedge clk) disable iff (rst)
    off_run_q <= RUN_W'(T_OFF_CYC));

  assert_probe_hit_no_normal_R5: assert property (@(posedge clk) disable iff (rst)
    (run_i && phase_w == PH_PROBE_ON && overload_i) |=> (phase_w != PH_NORMAL));

  assert_recover_keeps_output_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(ovl_flag_o) && $past(run_i)) |-> out_en_o);

  assert_static_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (run_i && phase_w == PH_NORMAL && clamp_mode_i)
      |=> (out_en_o && (ovl_flag_o == $past(overload_i))));

endmodule

bind ovl_guard ovl_guard_chk #(.T_OFF_CYC(T_OFF_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_i       (run_i),
  .clamp_mode_i(clamp_mode_i),
  .overload_i  (overload_i),
  .out_en_o    (out_en_o),
  .ovl_flag_o  (ovl_flag_o),
  .phase_w     (phase_w)
);

// File: tb/sim_ovl_guard.sv
`timescale 1ns/1ps
module sim_ovl_guard;

  localparam int TOFF = 20;
  localparam int TON  = (TOFF / 10 < 1) ? 1 : TOFF / 10;
  localparam int NVEC = 14;

  // {run, clamp_mode, overload, expected out_en, expected flag}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b11010,  // R2 standby to normal
    5'b11111,  // R7 flag follows overload
    5'b11111,  // R7
    5'b11010,  // R7 flag clears at once
    5'b01100,  // R1 standby
    5'b11010,  // R2 re-enter normal
    5'b10010,  // R8 mode 1->0 in normal
    5'b10101,  // R3 hiccup trip
    5'b00100,  // R1 abort off window
    5'b10010,  // R1 fresh normal
    5'b10101,  // R3 trip again
    5'b11101,  // R8 mode ignored while off
    5'b00000,  // R1 standby
    5'b10010   // R2 normal, dynamic
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic md  = 1'b0;
  logic ov  = 1'b0;
  logic out_en, flag;
  int   checks = 0;
  int   fails  = 0;

  always #2.5 clk = ~clk;

  ovl_guard #(.T_OFF_CYC(TOFF)) u0 (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run),
    .clamp_mode_i(md),
    .overload_i  (ov),
    .out_en_o    (out_en),
    .ovl_flag_o  (flag)
  );

  task automatic drive(input logic r, input logic m, input logic o);
    @(negedge clk);
    run = r; md = m; ov = o;
    @(posedge clk);
    #1;
  endtask

  task automatic expect2(input logic eo, input logic ef, input string what);
    checks++;
    if (out_en !== eo || flag !== ef) begin
      fails++;
      $display("FAIL %s: out_en=%b flag=%b expected out_en=%b flag=%b",
               what, out_en, flag, eo, ef);
    end
  endtask

  // trip plus the rest of the off window (R3, R4)
  task automatic trip_and_off(input logic m_during);
    drive(1'b1, 1'b0, 1'b1);
    expect2(1'b0, 1'b1, "R3 trip");
    for (int k = 1; k < TOFF; k++) begin
      drive(1'b1, m_during, 1'b1);
      expect2(1'b0, 1'b1, "R4 off window, overload ignored");
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    expect2(1'b0, 1'b0, "R2 reset state");
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0);
    expect2(1'b0, 1'b0, "R1 standby after reset");

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][4], VEC[i][3], VEC[i][2]);
      expect2(VEC[i][1], VEC[i][0], $sformatf("R1 R2 R3 R7 R8 table row %0d", i));
    end

    // clean recovery: first on edge, TON-1 samples, decision sample
    trip_and_off(1'b0);
    drive(1'b1, 1'b0, 1'b1);
    expect2(1'b1, 1'b1, "R4 on window start, changeover sample ignored");
    for (int k = 1; k < TON; k++) begin
      drive(1'b1, 1'b0, 1'b0);
      expect2(1'b1, 1'b1, "R4 on window");
    end
    drive(1'b1, 1'b0, 1'b0);
    expect2(1'b1, 1'b0, "R6 clean on window recovers");
    drive(1'b1, 1'b0, 1'b0);
    expect2(1'b1, 1'b0, "R6 stays normal");

    // overload on the first on-window sample only
    trip_and_off(1'b0);
    drive(1'b1, 1'b0, 1'b0);
    expect2(1'b1, 1'b1, "R4 on window start");
    drive(1'b1, 1'b0, 1'b1);
    expect2(1'b1, 1'b1, "R5 window not cut short");
    for (int k = 2; k < TON; k++) begin
      drive(1'b1, 1'b0, 1'b0);
      expect2(1'b1, 1'b1, "R5 window continues");
    end
    drive(1'b1, 1'b0, 1'b0);
    expect2(1'b0, 1'b1, "R5 remembered overload retrips");
    for (int k = 1; k < TOFF; k++) begin
      drive(1'b1, 1'b0, 1'b0);
      expect2(1'b0, 1'b1, "R4 second off window");
    end
    drive(1'b1, 1'b0, 1'b0);
    expect2(1'b1, 1'b1, "R4 second on window");
    for (int k = 1; k < TON; k++) begin
      drive(1'b1, 1'b0, 1'b0);
      expect2(1'b1, 1'b1, "R4 second on window");
    end
    drive(1'b1, 1'b0, 1'b0);
    expect2(1'b1, 1'b0, "R6 recovery after retrip");

    // overload only on the final sample
    trip_and_off(1'b0);
    drive(1'b1, 1'b0, 1'b0);
    expect2(1'b1, 1'b1, "R4 on window start");
    for (int k = 1; k < TON; k++) begin
      drive(1'b1, 1'b0, 1'b0);
      expect2(1'b1, 1'b1, "R4 on window");
    end
    drive(1'b1, 1'b0, 1'b1);
    expect2(1'b0, 1'b1, "R5 final-edge overload retrips");

    // mode raised mid-cycle: cycle runs out, then static rules apply
    for (int k = 1; k < TOFF; k++) begin
      drive(1'b1, 1'b1, 1'b0);
      expect2(1'b0, 1'b1, "R8 mode change ignored while off");
    end
    for (int k = 0; k < TON; k++) begin
      drive(1'b1, 1'b1, 1'b0);
      expect2(1'b1, 1'b1, "R8 on window kept");
    end
    drive(1'b1, 1'b1, 1'b0);
    expect2(1'b1, 1'b0, "R8 back to normal");
    drive(1'b1, 1'b1, 1'b1);
    expect2(1'b1, 1'b1, "R7 static flag set, output on");
    drive(1'b1, 1'b1, 1'b0);
    expect2(1'b1, 1'b0, "R7 static flag clear");

    // abort inside the on window with an overload pending
    trip_and_off(1'b0);
    drive(1'b1, 1'b0, 1'b0);
    expect2(1'b1, 1'b1, "R4 on window start");
    drive(1'b0, 1'b0, 1'b1);
    expect2(1'b0, 1'b0, "R1 abort in on window");
    drive(1'b1, 1'b0, 1'b0);
    expect2(1'b1, 1'b0, "R1 restart in normal");
    for (int k = 0; k < TOFF + TON; k++) begin
      drive(1'b1, 1'b0, 1'b0);
      expect2(1'b1, 1'b0, "R1 no remembered overload");
    end

    summary();
  end

endmodule